// File: doc/BRIEF.md
# Path Status Byte Monitor

This block watches the path status byte delivered once per received frame. Each byte comes with a one-cycle valid strobe. The block does two things with it. It debounces the remote defect indication bit into a stable flag. It also adds up the remote error indications carried in the byte's upper nibble into a 16-bit performance count, which is presented as a high byte and a low byte.

Three configuration inputs control the block:
- A persistence select picks whether the defect flag changes after 5 or after 10 consecutive differing bytes.
- A mode select picks whether the counter adds the number of errors reported in each byte, or adds one block per errored byte.
- A clear request zeroes the count through a control bit that clears itself.

Cycles without the valid strobe are ignored by both functions.

Top module: `path_status_mon`

## Requirements
- R1: The defect indication is taken from `g1_byte_i[3]` (mask 8'h08). No other bit of the byte affects the defect flag.
- R2: With `persist_short_i`=1, `rdi_o` changes state after the 5th consecutive valid byte whose defect bit differs from `rdi_o`. After 4 such bytes it does not change.
- R3: With `persist_short_i`=0, `rdi_o` changes state after the 10th consecutive differing valid byte. After 9 such bytes it does not change. The same rule applies to declaring and to clearing.
- R4: A valid byte whose defect bit equals the current `rdi_o` restarts the run. Cycles without `g1_valid_i` neither count toward a run nor break it.
- R5: A change of `persist_short_i` clears the run in progress. A valid byte in a cycle where the select differs from its previous-cycle value is not counted.
- R6: In individual mode (`rei_block_mode_i`=0), a valid byte adds its upper nibble `g1_byte_i[7:4]` to the count when that nibble is 1 to 8. Nibble values 0 and 9 to 15 add nothing.
- R7: In block mode (`rei_block_mode_i`=1), a valid byte whose nibble is 1 to 8 adds exactly 1. Any other nibble adds nothing.
- R8: A one-cycle pulse on `rei_clear_i` sets an internal clear bit at the next edge. The count reads zero after the edge that follows, and the clear bit drops with no further request. A byte presented while the clear bit is set is not counted.
- R9: The count saturates at 16'hFFFF and does not wrap.
- R10: `rei_cnt_hi_o` carries count bits 15:8 and `rei_cnt_lo_o` carries bits 7:0.
- R11: While `rst_ni` is low, `rdi_o` is 0 and the count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| g1_valid_i | input | 1 | Path status byte strobe, one cycle per frame |
| g1_byte_i | input | 8 | Received path status byte |
| persist_short_i | input | 1 | 1: 5-byte persistence, 0: 10-byte persistence |
| rei_block_mode_i | input | 1 | 1: count errored bytes, 0: count individual errors |
| rei_clear_i | input | 1 | Clear request for the error count |
| rdi_o | output | 1 | Debounced remote defect flag |
| rei_cnt_hi_o | output | 8 | Error count, upper byte |
| rei_cnt_lo_o | output | 8 | Error count, lower byte |

## Verification
The hardest state to reach from the ports is a saturated counter. Getting there takes more than eight thousand maximum-weight bytes. The stimulus streams nibble-8 bytes up to 65528, checks how the two output bytes split that value, then steps to the ceiling and pushes one more byte against it. A second hard case is a persistence-select change in the middle of a run. The bench builds a partial run, toggles the select during idle cycles, and then shows that a complete new run is needed before the flag changes.

// File: rtl/psm_pkg.sv
package psm_pkg;
  localparam int unsigned BYTE_W      = 8;
  localparam int unsigned RDI_POS     = 3;
  localparam int unsigned REI_HI      = 7;
  localparam int unsigned REI_LO      = 4;
  localparam int unsigned REI_W       = REI_HI - REI_LO + 1;
  localparam int unsigned REI_MAX_ERR = 8;

  function automatic logic [REI_W-1:0] rei_errs(input logic [REI_W-1:0] nib);
    return (nib <= REI_W'(REI_MAX_ERR)) ? nib : '0;
  endfunction
endpackage

// File: rtl/rdi_debounce.sv
module rdi_debounce #(
  parameter int unsigned SHORT_RUN = 5,
  parameter int unsigned LONG_RUN  = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic bit_i,
  input  logic sel_short_i,
  output logic rdi_o
);
  localparam int unsigned RUN_W = $clog2(LONG_RUN + 1);

  logic [RUN_W-1:0] run_q, thresh, run_nx;
  logic             rdi_q, sel_q, sel_chg;

  assign thresh  = sel_short_i ? RUN_W'(SHORT_RUN) : RUN_W'(LONG_RUN);
  assign sel_chg = sel_short_i != sel_q;
  assign run_nx  = run_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= '0;
      rdi_q <= 1'b0;
      sel_q <= 1'b1;
    end else begin
      sel_q <= sel_short_i;
      if (sel_chg) begin
        run_q <= '0;
      end else if (valid_i) begin
        if (bit_i == rdi_q) begin
          run_q <= '0;
        end else if (run_nx == thresh) begin
          rdi_q <= ~rdi_q;
          run_q <= '0;
        end else begin
          run_q <= run_nx;
        end
      end
    end
  end

  assign rdi_o = rdi_q;

  // R2 R3: the run never reaches the active threshold while the select is stable
  a_r3_run_below_thresh: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_chg |-> run_q < thresh);

  // R4: the flag moves only on a counted valid byte
  a_r4_flip_needs_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdi_q != $past(rdi_q)) |-> ($past(valid_i) && !$past(sel_chg)));

  // R4: a flip starts a fresh run
  a_r4_flip_clears_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdi_q != $past(rdi_q)) |-> run_q == '0);

  // R5: a select change clears the run
  a_r5_sel_change_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_chg |=> run_q == '0);
endmodule

// File: rtl/rei_accum.sv
module rei_accum
  import psm_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [REI_W-1:0] nib_i,
  input  logic             block_mode_i,
  input  logic             clear_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   sum;
  logic [REI_W-1:0] errs, inc;
  logic             clr_q;

  assign errs = rei_errs(nib_i);
  assign inc  = !valid_i     ? '0 :
                block_mode_i ? REI_W'(errs != '0) : errs;
  assign sum  = {1'b0, cnt_q} + (CNT_W + 1)'(inc);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      clr_q <= 1'b0;
    end else begin
      clr_q <= clear_i;  // self-clearing control bit
      if (clr_q)         cnt_q <= '0;
      else if (sum[CNT_W]) cnt_q <= '1;
      else               cnt_q <= sum[CNT_W-1:0];
    end
  end

  assign cnt_o = cnt_q;

  // R8: the control bit zeroes the count on the next edge
  a_r8_clear_zeroes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_q |=> cnt_q == '0);

  // R8: the control bit drops without a new request
  a_r8_self_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_q && !clear_i) |=> !clr_q);

  // R6 R7 R9: outside a clear the count never decreases
  a_r9_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_q |=> cnt_q >= $past(cnt_q));

  // R7: block mode adds at most one
  a_r7_block_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_q && block_mode_i) |=> (cnt_q - $past(cnt_q)) <= CNT_W'(1));

  // R6: a step never exceeds the largest legal error count
  a_r6_step_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_q |=> (cnt_q - $past(cnt_q)) <= CNT_W'(REI_MAX_ERR));
endmodule

// File: rtl/path_status_mon.sv
module path_status_mon
  import psm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              g1_valid_i,
  input  logic [BYTE_W-1:0] g1_byte_i,
  input  logic              persist_short_i,
  input  logic              rei_block_mode_i,
  input  logic              rei_clear_i,
  output logic              rdi_o,
  output logic [BYTE_W-1:0] rei_cnt_hi_o,
  output logic [BYTE_W-1:0] rei_cnt_lo_o
);
  localparam int unsigned CNT_W = 2 * BYTE_W;

  logic [CNT_W-1:0] cnt;

  rdi_debounce #(
    .SHORT_RUN(5),
    .LONG_RUN (10)
  ) u_rdi (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (g1_valid_i),
    .bit_i      (g1_byte_i[RDI_POS]),
    .sel_short_i(persist_short_i),
    .rdi_o      (rdi_o)
  );

  rei_accum #(
    .CNT_W(CNT_W)
  ) u_rei (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .valid_i     (g1_valid_i),
    .nib_i       (g1_byte_i[REI_HI:REI_LO]),
    .block_mode_i(rei_block_mode_i),
    .clear_i     (rei_clear_i),
    .cnt_o       (cnt)
  );

  assign rei_cnt_hi_o = cnt[CNT_W-1:BYTE_W];
  assign rei_cnt_lo_o = cnt[BYTE_W-1:0];

  // R11: reset state at the ports
  a_r11_reset_state: assert property (@(posedge clk_i)
    !rst_ni |-> (!rdi_o && rei_cnt_hi_o == '0 && rei_cnt_lo_o == '0));
endmodule

// File: tb/tb_path_status_mon.sv
module tb_path_status_mon;
  localparam int unsigned HALF = 10;  // 50 MHz

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       g1_valid_i = 1'b0;
  logic [7:0] g1_byte_i = '0;
  logic       persist_short_i = 1'b1;
  logic       rei_block_mode_i = 1'b0;
  logic       rei_clear_i = 1'b0;
  logic       rdi_o;
  logic [7:0] rei_cnt_hi_o, rei_cnt_lo_o;

  int errors = 0;
  int checks = 0;
  int exp_cnt = 0;

  always #(HALF) clk_i = ~clk_i;

  path_status_mon dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .g1_valid_i(g1_valid_i), .g1_byte_i(g1_byte_i),
    .persist_short_i(persist_short_i), .rei_block_mode_i(rei_block_mode_i),
    .rei_clear_i(rei_clear_i), .rdi_o(rdi_o), .rei_cnt_hi_o(rei_cnt_hi_o),
    .rei_cnt_lo_o(rei_cnt_lo_o)
  );

  // {block_mode, g1 byte, expected increment}
  localparam logic [12:0] VEC [12] = '{
    {1'b0, 8'h10, 4'd1}, {1'b0, 8'h80, 4'd8}, {1'b0, 8'h90, 4'd0},
    {1'b0, 8'hF0, 4'd0}, {1'b0, 8'h00, 4'd0}, {1'b0, 8'h50, 4'd5},
    {1'b0, 8'h28, 4'd2}, {1'b1, 8'h80, 4'd1}, {1'b1, 8'h10, 4'd1},
    {1'b1, 8'hA0, 4'd0}, {1'b1, 8'h37, 4'd1}, {1'b1, 8'h00, 4'd0}
  };

  task automatic check(input int act, input int exp, input string req);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    g1_byte_i = b;
    g1_valid_i = 1'b1;
    @(negedge clk_i);
    g1_valid_i = 1'b0;
    g1_byte_i = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic clear_cnt();
    rei_clear_i = 1'b1;
    @(negedge clk_i);
    rei_clear_i = 1'b0;
    @(negedge clk_i);
  endtask

  function automatic int cnt();
    return {rei_cnt_hi_o, rei_cnt_lo_o};
  endfunction

  initial begin
    #(2 * HALF * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle(3);
    check(rdi_o, 0, "R11 rdi");
    check(cnt(), 0, "R11 count");
    rst_ni = 1'b1;
    idle(2);

    // R6 R7: vector table
    for (int i = 0; i < 12; i++) begin
      rei_block_mode_i = VEC[i][12];
      send(VEC[i][11:4]);
      exp_cnt += int'(VEC[i][3:0]);
      check(cnt(), exp_cnt, VEC[i][12] ? "R7 block" : "R6 individual");
    end
    check(rdi_o, 0, "R1 isolated defect bit");
    rei_block_mode_i = 1'b0;

    // R1: other bits do not feed the defect flag
    for (int i = 0; i < 6; i++) send(8'hF7);
    check(rdi_o, 0, "R1 other bits");

    // R2: 5-byte persistence
    clear_cnt();
    check(cnt(), 0, "R8 cleared");
    for (int i = 0; i < 4; i++) send(8'h08);
    check(rdi_o, 0, "R2 four bytes");
    send(8'h08);
    check(rdi_o, 1, "R2 fifth byte declares");

    // R4: a matching byte restarts; idle cycles are transparent
    for (int i = 0; i < 4; i++) send(8'h00);
    send(8'h08);
    for (int i = 0; i < 2; i++) send(8'h00);
    idle(3);
    for (int i = 0; i < 2; i++) send(8'h00);
    check(rdi_o, 1, "R4 restarted run");
    send(8'h00);
    check(rdi_o, 0, "R4 run across idle clears");

    // R5: select change drops a partial run
    for (int i = 0; i < 4; i++) send(8'h08);
    persist_short_i = 1'b0; idle(1);
    persist_short_i = 1'b1; idle(1);
    for (int i = 0; i < 4; i++) send(8'h08);
    check(rdi_o, 0, "R5 run cleared by select change");
    send(8'h08);
    check(rdi_o, 1, "R5 full run after change");

    // R3: 10-byte persistence for clearing
    persist_short_i = 1'b0; idle(1);
    for (int i = 0; i < 9; i++) send(8'h00);
    check(rdi_o, 1, "R3 nine bytes");
    send(8'h00);
    check(rdi_o, 0, "R3 tenth byte clears");
    for (int i = 0; i < 9; i++) send(8'h08);
    check(rdi_o, 0, "R3 nine bytes declare");
    send(8'h08);
    check(rdi_o, 1, "R3 tenth byte declares");

    // R8: byte during the clear bit is dropped; the bit self-clears
    send(8'h30);
    rei_clear_i = 1'b1;
    @(negedge clk_i);
    rei_clear_i = 1'b0;
    send(8'h50);
    check(cnt(), 0, "R8 byte during clear dropped");
    send(8'h20);
    check(cnt(), 2, "R8 counting resumes");

    // R9 R10: saturation
    clear_cnt();
    for (int i = 0; i < 8191; i++) send(8'h80);
    check(rei_cnt_hi_o, 8'hFF, "R10 high byte");
    check(rei_cnt_lo_o, 8'hF8, "R10 low byte");
    send(8'h70);
    check(cnt(), 16'hFFFF, "R9 reaches ceiling");
    send(8'h80);
    check(cnt(), 16'hFFFF, "R9 no wrap");

    // R11: reset mid-operation
    rst_ni = 1'b0;
    idle(1);
    check(rdi_o, 0, "R11 rdi after reset");
    check(cnt(), 0, "R11 count after reset");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule